// File: doc/BRIEF.md
# Programmable Timing NCO Accumulator

This block is a numerically controlled oscillator that drives a downstream resampling filter. There is no sine or cosine lookup. A 32-bit phase accumulator advances once per enabled clock by an increment. The increment is a center-frequency word, plus an optional offset-frequency word when that word is enabled. The carry out of the accumulator becomes a one-cycle filter strobe that tells the resampler to run. The top accumulator bits, shifted by an 8-bit phase offset, supply a 5-bit filter phase select.

Frequency and phase words go through a staging register first. A software-style write fills the staged copy, and a separate one-cycle strobe moves it into the active copy, so the accumulator never sees a half-written value. The offset-frequency word arrives one bit at a time, MSB first, through a shift register. A transfer pulse moves it into the active offset register at a selectable length.

A clear control zeroes the accumulator. When load-on-update is set, an update event reloads the accumulator instead of letting it run through that cycle. The update event comes from an internal update pulse or from an external sync input, depending on a sync-select bit.

Top module: `timing_nco`

## Requirements
- R1: After reset, the filter strobe is low and the filter phase select is 0. The accumulator, every staged word, every active word and the offset shift register are all zero.
- R2: On each cycle with `clk_en` high (and no clear or load), the accumulator becomes (accumulator + increment) mod 2^32. The increment is the active center frequency plus the active offset term. While `clk_en` is low the accumulator holds and the strobe stays low.
- R3: `filt_strobe` is high for exactly the one cycle that follows an enabled edge whose addition carried out of bit 31. Otherwise it is low.
- R4: `filt_phase` equals bits [7:3] of (accumulator[31:24] + active phase offset) mod 256.
- R5: `cf_wr` loads `cf_word` into the staged center frequency. The active center frequency takes the staged value only on an edge with `freq_strobe` high, and it takes the staged value held before that edge.
- R6: `ph_wr` loads `ph_word` into the staged phase offset. The active phase offset takes the staged value only on an edge with `phase_strobe` high.
- R7: On an edge with `ofs_shift` high, the shift register moves left by one and takes in `ofs_sdata` (MSB first). On an edge with `ofs_xfer` high, the active offset takes the low N bits of the shift register, left-aligned into 32 bits with zero fill. N is set by `cfg_ofs_len`: 0 gives 8, 1 gives 16, 2 gives 24, 3 gives 32.
- R8: When `cfg_ofs_en` is low, the offset term in the increment is zero. When it is high, the offset term is the active offset word.
- R9: On an enabled edge with `cfg_acc_clear` high, the accumulator becomes 0 and no strobe is produced. Clear has priority over load and accumulate.
- R10: On an enabled edge with `cfg_load_on_update` high and an update event, the accumulator is loaded with the increment and no strobe is produced.
- R11: The update event is `ext_sync` when `cfg_ext_sync_en` is high, and `upd_int` when it is low. The input that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Accumulator advance enable |
| cfg_ext_sync_en | input | 1 | Selects `ext_sync` as the update event source |
| cfg_ofs_len | input | 2 | Offset word length select (8/16/24/32 bits) |
| cfg_ofs_en | input | 1 | Adds the offset term to the increment |
| cfg_acc_clear | input | 1 | Forces the accumulator to zero |
| cfg_load_on_update | input | 1 | Reloads the accumulator on an update event |
| cf_word | input | 32 | Center frequency write data |
| cf_wr | input | 1 | Writes the staged center frequency |
| freq_strobe | input | 1 | Moves the staged center frequency into the active copy |
| ph_word | input | 8 | Phase offset write data |
| ph_wr | input | 1 | Writes the staged phase offset |
| phase_strobe | input | 1 | Moves the staged phase offset into the active copy |
| ofs_sdata | input | 1 | Serial offset data bit |
| ofs_shift | input | 1 | Shifts `ofs_sdata` into the offset shift register |
| ofs_xfer | input | 1 | Transfers the shift register into the active offset |
| upd_int | input | 1 | Internal update pulse |
| ext_sync | input | 1 | External sync pulse |
| filt_strobe | output | 1 | Resampler run strobe (accumulator carry) |
| filt_phase | output | 5 | Resampler filter phase select |

## Verification
The bench writes staged words and holds off the strobes for several cycles. A design that leaked staged values straight through would show the phase moving too early. Offset words are shifted in at all four lengths, and the offset is added both with its enable low and with it high. A wrong left-alignment, a wrong bit order or an offset that ignores its enable would skew the strobe spacing and the phase sequence. Clear, load-on-update and the sync selection are exercised one at a time, and the bench also pulses the update input that is not selected. A design that gave these controls the wrong priority, or that followed that unselected pulse, would produce a spurious strobe or a phase that restarts when it should not.

// File: rtl/tnco_pkg.sv
package tnco_pkg;

    typedef enum logic [1:0] {
        OFS_QUARTER = 2'd0,
        OFS_HALF    = 2'd1,
        OFS_3QUART  = 2'd2,
        OFS_FULL    = 2'd3
    } ofs_len_e;

    // Number of offset bits kept for a given length code.
    function automatic int unsigned ofs_len_bits(input logic [1:0] sel, input int unsigned acc_w);
        return (int'(sel) + 1) * (acc_w / 4);
    endfunction

endpackage

// File: rtl/tnco_stage.sv
module tnco_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         xfer,
    output logic [W-1:0] active
);

    typedef struct packed {
        logic [W-1:0] staged;
        logic [W-1:0] live;
    } stage_t;

    stage_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr)   s_d.staged = wdata;
        if (xfer) s_d.live   = s_q.staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.live;

    // R5 / R6: the active copy moves only on its transfer strobe
    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(active));

    p_active_takes_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr) |=> (active == s_q.staged));

endmodule

// File: rtl/tnco_ofs_sreg.sv
module tnco_ofs_sreg
    import tnco_pkg::*;
#(
    parameter int unsigned ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdata,
    input  logic             xfer,
    input  logic [1:0]       len_sel,
    output logic [ACC_W-1:0] ofs_word
);

    typedef struct packed {
        logic [ACC_W-1:0] sr;
        logic [ACC_W-1:0] ofs;
    } osr_t;

    osr_t o_d, o_q;
    int unsigned keep_bits;
    logic [ACC_W-1:0] aligned;

    always_comb begin
        keep_bits = ofs_len_bits(len_sel, ACC_W);
        aligned   = o_q.sr << (ACC_W - keep_bits);
        o_d = o_q;
        if (shift_en) o_d.sr  = {o_q.sr[ACC_W-2:0], sdata};
        if (xfer)     o_d.ofs = aligned;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign ofs_word = o_q.ofs;

    // R7: a short word leaves the low bits zero
    p_ofs_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && len_sel == OFS_QUARTER) |=> (ofs_word[ACC_W-ACC_W/4-1:0] == '0));

    p_ofs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(ofs_word));

endmodule

// File: rtl/tnco_phase_acc.sv
module tnco_phase_acc #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned PH_W  = 8,
    parameter int unsigned SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             clear,
    input  logic             load_evt,
    input  logic [ACC_W-1:0] inc,
    input  logic [PH_W-1:0]  ph_ofs,
    output logic             strobe,
    output logic [SEL_W-1:0] phase_sel
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             stb;
    } acc_t;

    acc_t a_d, a_q;
    logic [ACC_W:0]  sum;
    logic [PH_W-1:0] adj;

    always_comb begin
        sum = {1'b0, a_q.acc} + {1'b0, inc};
        a_d = a_q;
        a_d.stb = 1'b0;
        if (clk_en) begin
            if (clear) begin
                a_d.acc = '0;
            end else if (load_evt) begin
                a_d.acc = inc;
            end else begin
                a_d.acc = sum[ACC_W-1:0];
                a_d.stb = sum[ACC_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign adj       = a_q.acc[ACC_W-1 -: PH_W] + ph_ofs;
    assign phase_sel = adj[PH_W-1 -: SEL_W];
    assign strobe    = a_q.stb;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(a_q.acc) && !strobe));

    p_strobe_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (a_q.acc < $past(a_q.acc)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && clear) |=> (a_q.acc == '0 && !strobe));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !clear && load_evt) |=> !strobe);

endmodule

// File: rtl/timing_nco.sv
module timing_nco
    import tnco_pkg::*;
#(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned PH_W  = 8,
    parameter int unsigned SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cfg_ext_sync_en,
    input  logic [1:0]       cfg_ofs_len,
    input  logic             cfg_ofs_en,
    input  logic             cfg_acc_clear,
    input  logic             cfg_load_on_update,
    input  logic [ACC_W-1:0] cf_word,
    input  logic             cf_wr,
    input  logic             freq_strobe,
    input  logic [PH_W-1:0]  ph_word,
    input  logic             ph_wr,
    input  logic             phase_strobe,
    input  logic             ofs_sdata,
    input  logic             ofs_shift,
    input  logic             ofs_xfer,
    input  logic             upd_int,
    input  logic             ext_sync,
    output logic             filt_strobe,
    output logic [SEL_W-1:0] filt_phase
);

    logic [ACC_W-1:0] cf_active;
    logic [PH_W-1:0]  ph_active;
    logic [ACC_W-1:0] ofs_active;
    logic [ACC_W-1:0] ofs_term;
    logic [ACC_W-1:0] inc;
    logic             upd_evt;
    logic             load_evt;

    tnco_stage #(.W(ACC_W)) u_cf_stage (
        .clk(clk), .rst_n(rst_n), .wr(cf_wr), .wdata(cf_word),
        .xfer(freq_strobe), .active(cf_active)
    );

    tnco_stage #(.W(PH_W)) u_ph_stage (
        .clk(clk), .rst_n(rst_n), .wr(ph_wr), .wdata(ph_word),
        .xfer(phase_strobe), .active(ph_active)
    );

    tnco_ofs_sreg #(.ACC_W(ACC_W)) u_ofs (
        .clk(clk), .rst_n(rst_n), .shift_en(ofs_shift), .sdata(ofs_sdata),
        .xfer(ofs_xfer), .len_sel(cfg_ofs_len), .ofs_word(ofs_active)
    );

    always_comb begin
        ofs_term = cfg_ofs_en ? ofs_active : '0;
        inc      = cf_active + ofs_term;
        upd_evt  = cfg_ext_sync_en ? ext_sync : upd_int;
        load_evt = cfg_load_on_update && upd_evt;
    end

    tnco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .SEL_W(SEL_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clear(cfg_acc_clear),
        .load_evt(load_evt), .inc(inc), .ph_ofs(ph_active),
        .strobe(filt_strobe), .phase_sel(filt_phase)
    );

    // R11: with external sync selected, the internal pulse alone does not load
    p_sync_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ext_sync_en && !ext_sync && upd_int && cfg_load_on_update) |-> !load_evt);

    // R8: offset disabled means the increment is the center frequency alone
    p_ofs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ofs_en |-> (inc == cf_active));

endmodule

// File: tb/timing_nco_tb.sv
module timing_nco_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        ext_en = 1'b0;
    logic [1:0]  ofs_len = 2'd0;
    logic        ofs_en = 1'b0;
    logic        acc_clear = 1'b0;
    logic        lou = 1'b0;
    logic [31:0] cf_word = '0;
    logic        cf_wr = 1'b0;
    logic        freq_strobe = 1'b0;
    logic [7:0]  ph_word = '0;
    logic        ph_wr = 1'b0;
    logic        phase_strobe = 1'b0;
    logic        ofs_sdata = 1'b0;
    logic        ofs_shift = 1'b0;
    logic        ofs_xfer = 1'b0;
    logic        upd_int = 1'b0;
    logic        ext_sync = 1'b0;
    logic        filt_strobe;
    logic [4:0]  filt_phase;

    always #10 clk = ~clk;

    timing_nco dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .cfg_ext_sync_en(ext_en), .cfg_ofs_len(ofs_len), .cfg_ofs_en(ofs_en),
        .cfg_acc_clear(acc_clear), .cfg_load_on_update(lou),
        .cf_word(cf_word), .cf_wr(cf_wr), .freq_strobe(freq_strobe),
        .ph_word(ph_word), .ph_wr(ph_wr), .phase_strobe(phase_strobe),
        .ofs_sdata(ofs_sdata), .ofs_shift(ofs_shift), .ofs_xfer(ofs_xfer),
        .upd_int(upd_int), .ext_sync(ext_sync),
        .filt_strobe(filt_strobe), .filt_phase(filt_phase)
    );

    typedef struct {
        logic       stb;
        logic [4:0] ph;
        string      tag;
    } exp_t;

    exp_t        sb_q[$];
    int          vectors = 0;
    int          miscompares = 0;
    string       cur_req = "R1";
    bit          done = 0;

    logic [31:0] m_cf_stage = '0, m_cf = '0, m_sr = '0, m_ofs = '0, m_acc = '0;
    logic [7:0]  m_ph_stage = '0, m_ph = '0;

    // driver: compute expected next outputs from the requirements, then clock
    task automatic step();
        logic [31:0] inc;
        logic [32:0] s;
        logic        upd;
        logic [7:0]  adj;
        exp_t        e;
        e.stb = 1'b0;
        inc = m_cf + (ofs_en ? m_ofs : 32'd0);
        upd = ext_en ? ext_sync : upd_int;
        if (clk_en) begin
            if (acc_clear) m_acc = '0;
            else if (upd && lou) m_acc = inc;
            else begin
                s = {1'b0, m_acc} + {1'b0, inc};
                m_acc = s[31:0];
                e.stb = s[32];
            end
        end
        if (freq_strobe)  m_cf = m_cf_stage;
        if (cf_wr)        m_cf_stage = cf_word;
        if (phase_strobe) m_ph = m_ph_stage;
        if (ph_wr)        m_ph_stage = ph_word;
        if (ofs_xfer)     m_ofs = m_sr << (32 - 8 * (int'(ofs_len) + 1));
        if (ofs_shift)    m_sr = {m_sr[30:0], ofs_sdata};
        adj  = m_acc[31:24] + m_ph;
        e.ph = adj[7:3];
        e.tag = cur_req;
        sb_q.push_back(e);
        @(negedge clk);
        cf_wr = 0; freq_strobe = 0; ph_wr = 0; phase_strobe = 0;
        ofs_shift = 0; ofs_xfer = 0; upd_int = 0; ext_sync = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic shift_word(input logic [31:0] v, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ofs_sdata = v[i];
            ofs_shift = 1'b1;
            step();
        end
    endtask

    // monitor: pop and compare once per cycle, away from the clock edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            vectors++;
            if (filt_strobe !== e.stb || filt_phase !== e.ph) begin
                miscompares++;
                $display("FAIL %s: strobe=%0b phase=%0d expected strobe=%0b phase=%0d",
                         e.tag, filt_strobe, filt_phase, e.stb, e.ph);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        vectors++;
        if (filt_strobe !== 1'b0 || filt_phase !== 5'd0) begin
            miscompares++;
            $display("FAIL R1: strobe=%0b phase=%0d expected strobe=0 phase=0", filt_strobe, filt_phase);
        end
        rst_n = 1'b1;
        @(negedge clk);
        clk_en = 1'b1;

        cur_req = "R1"; run(2);

        // R5: staged frequency must not act before the strobe
        cur_req = "R5";
        cf_word = 32'h1000_0000; cf_wr = 1; step();
        run(3);
        freq_strobe = 1; step();

        // R2 / R3: steady accumulation with wraps every 16 cycles
        cur_req = "R3"; run(36);
        cur_req = "R2"; clk_en = 0; run(4); clk_en = 1; run(3);

        // R5: write and strobe in the same cycle uses the older staged value
        cur_req = "R5";
        cf_word = 32'h0C00_0000; cf_wr = 1; step();
        cf_word = 32'h2200_0000; cf_wr = 1; freq_strobe = 1; step();
        run(10);
        freq_strobe = 1; step(); run(8);

        // R6 / R4: phase offset
        cur_req = "R6";
        ph_word = 8'h48; ph_wr = 1; step(); run(3);
        phase_strobe = 1; step();
        cur_req = "R4"; run(12);
        ph_word = 8'hF9; ph_wr = 1; step(); phase_strobe = 1; step(); run(6);

        // R7 / R8: serial offset, all four lengths
        cf_word = 32'h0100_0000; cf_wr = 1; step(); freq_strobe = 1; step();
        cur_req = "R7"; ofs_len = 2'd0; shift_word(32'h0000_00A5, 8);
        ofs_xfer = 1; step();
        cur_req = "R8"; ofs_en = 0; run(6);
        ofs_en = 1; run(8);
        cur_req = "R7";
        ofs_len = 2'd1; shift_word(32'h0000_3C81, 16); ofs_xfer = 1; step(); run(8);
        ofs_len = 2'd2; shift_word(32'h0012_3456, 24); ofs_xfer = 1; step(); run(8);
        ofs_len = 2'd3; shift_word(32'h0F1E_2D3C, 32); ofs_xfer = 1; step(); run(8);
        ofs_en = 0; run(3);

        // R9: clear has priority over load
        cur_req = "R9";
        acc_clear = 1; lou = 1; upd_int = 1; step();
        run(1); acc_clear = 0; lou = 0; run(5);

        // R10: load on update
        cur_req = "R10";
        lou = 1; run(4);
        upd_int = 1; step(); run(4);
        upd_int = 1; step(); run(3);

        // R11: sync source selection
        cur_req = "R11";
        ext_en = 1; run(2);
        upd_int = 1; step(); run(3);
        ext_sync = 1; step(); run(3);
        ext_en = 0; ext_sync = 1; step(); run(3);
        lou = 0; run(4);

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule